// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm

This peripheral keeps wall-clock time as a plain count of seconds. A clock-enable input, pulsed at 32.768 kHz, drives a prescaler. The prescaler produces one tick per second and can also apply a small periodic correction. Each tick adds one to a 32-bit seconds register. When a tick brings that register to the value held in a 32-bit alarm register, an alarm event is raised.

A control and status register holds the two event flags (alarm and one-second) and their two interrupt enables. Software clears a flag by writing a one to it. Each interrupt output is the AND of its flag and its enable. All four registers sit on a simple bus. A write is taken on the clock edge, and read data is valid in the same cycle the address is presented.

Top module: `rtc_seconds`

## Requirements
- R1: After reset the alarm, seconds, divider/trim and status registers all read zero, and both interrupt outputs are low.
- R2: Word address 0 is the alarm register, 1 the seconds register, 2 the divider/trim register and 3 the status register. Status bit 0 is the alarm flag, bit 1 the one-second flag, bit 2 the alarm enable and bit 3 the one-second enable. Status bits 31:4 read zero.
- R3: With a nonzero divider/trim register, a tick is produced once every divider+1 enable pulses, where the divider is bits 15:0. A write to the divider/trim register restarts the prescaler and its correction sequence from zero.
- R4: While the divider/trim register holds zero, the prescaler behaves as if the divider were 32767 with no correction, giving one tick per 32768 enable pulses.
- R5: Bits 31:16 hold a signed (two's complement) correction. The period of every 1024th tick after a restart is divider+1+correction enable pulses. All other periods are unchanged.
- R6: The seconds register loads the written value and increments by one on each tick. A write in the same cycle as a tick takes precedence over the tick.
- R7: The alarm flag is set when a tick advances the seconds register to a value equal to the alarm register. Writing the seconds register to the alarm value does not set the flag.
- R8: Writing 1 to a status flag bit clears that flag. Writing 0 leaves the flag unchanged.
- R9: Flags are recorded whatever the enables hold. An interrupt output is high only while its flag and its enable are both set.
- R10: If an event occurs in the same cycle as a write that clears its flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse at the 32.768 kHz reference rate |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| irq_alarm | output | 1 | Alarm interrupt (flag AND enable) |
| irq_sec | output | 1 | One-second interrupt (flag AND enable) |

## Verification
The bench gates the enable input precisely. This lets it land on the exact enable pulse where a tick should or should not occur. A prescaler off by one in its wrap test, or one that ignores the zero-means-default rule, shows a wrong seconds value at those boundaries.

The bench applies positive and negative corrections and checks the 1024th period. A design that trims the wrong period, or every period, is caught there.

The bench also makes a flag clear and a tick collide in one cycle. A design that lets the clear win loses the event. It also writes zeros and all-ones to status. A design that clears flags on zero, or returns garbage in the unused bits, fails those reads. Finally, it loads the seconds register with the alarm value directly, which must not raise the alarm.

// File: rtl/rtc_pkg.sv
// Package: shared register addresses and status bit positions for the
// seconds RTC. Assumes a 2-bit word address bus.
package rtc_pkg;
    typedef enum logic [1:0] {
        REG_ALARM = 2'd0,
        REG_COUNT = 2'd1,
        REG_CFG   = 2'd2,
        REG_STAT  = 2'd3
    } rtc_reg_e;

    localparam int ST_ALM_FLAG = 0;
    localparam int ST_SEC_FLAG = 1;
    localparam int ST_ALM_EN   = 2;
    localparam int ST_SEC_EN   = 3;
    localparam int ST_W        = 4;
endpackage

// File: rtl/rtc_prescaler.sv
// Module: rtc_prescaler
// Holds the divider/trim register and divides reference enables down to a
// one-cycle seconds tick. The divider is in the low DIV_W bits and the
// signed trim in the high TRIM_W bits. A zero register selects DEF_DIV
// with no trim. The trim applies to the last period of every TRIM_PERIOD
// ticks. Assumes TRIM_W <= DIV_W+2 and TRIM_PERIOD a power of two >= 2.
module rtc_prescaler #(
    parameter int DIV_W       = 16,
    parameter int TRIM_W      = 16,
    parameter int DEF_DIV     = 32767,
    parameter int TRIM_PERIOD = 1024,
    localparam int CFG_W      = DIV_W + TRIM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_q,
    output logic             sec_tick
);
    localparam int LW    = DIV_W + 2;
    localparam int PW    = DIV_W + 1;
    localparam int IDX_W = $clog2(TRIM_PERIOD);

    logic [PW-1:0]     pcnt_q;
    logic [IDX_W-1:0]  tidx_q;
    logic              use_def;
    logic [DIV_W-1:0]  div_eff;
    logic [TRIM_W-1:0] trim_eff;
    logic [LW-1:0]     trim_ext;
    logic [LW-1:0]     lim_sum;
    logic [PW-1:0]     limit;
    logic              trim_slot;
    logic              wrap;

    // Effective divider, trim and wrap limit for the current period.
    always_comb begin
        use_def   = (cfg_q == '0);
        div_eff   = use_def ? DIV_W'(DEF_DIV) : cfg_q[DIV_W-1:0];
        trim_eff  = use_def ? '0 : cfg_q[CFG_W-1:DIV_W];
        trim_ext  = {{(LW-TRIM_W){trim_eff[TRIM_W-1]}}, trim_eff};
        trim_slot = (tidx_q == IDX_W'(TRIM_PERIOD - 1));
        lim_sum   = {2'b00, div_eff} + (trim_slot ? trim_ext : '0);
        limit     = lim_sum[LW-1] ? '0 : lim_sum[PW-1:0];
        wrap      = (pcnt_q >= limit);
        sec_tick  = tick_en && wrap && !cfg_wr;
    end

    // Divider/trim register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= cfg_wdata;
    end

    // Prescale counter and trim-period index; a config write restarts both.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_wr) begin
            pcnt_q <= '0;
            tidx_q <= '0;
        end else if (tick_en) begin
            if (wrap) begin
                pcnt_q <= '0;
                tidx_q <= tidx_q + 1'b1;
            end else begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end

    // R3
    pcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !sec_tick && !cfg_wr) |=> pcnt_q == $past(pcnt_q) + 1'b1);
endmodule

// File: rtl/rtc_timebase.sv
// Module: rtc_timebase
// Seconds counter and alarm register. The counter loads on a write and
// otherwise advances on each tick. alarm_evt pulses when a tick (not a
// write) brings the counter to the alarm value.
module rtc_timebase #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             cnt_wr,
    input  logic             alm_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] alm_q,
    output logic             alarm_evt
);
    logic [CNT_W-1:0] cnt_nxt;

    // Next counter value on a tick, and the match against the alarm.
    always_comb begin
        cnt_nxt   = cnt_q + 1'b1;
        alarm_evt = sec_tick && !cnt_wr && (cnt_nxt == alm_q);
    end

    // Seconds counter: a write wins over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (cnt_wr)   cnt_q <= wdata;
        else if (sec_tick) cnt_q <= cnt_nxt;
    end

    // Alarm compare register.
    always_ff @(posedge clk) begin
        if (!rst_n)      alm_q <= '0;
        else if (alm_wr) alm_q <= wdata;
    end

    // R6
    cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !cnt_wr) |=> cnt_q == $past(cnt_q) + 1'b1);
    // R6
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt_q == $past(wdata));
endmodule

// File: rtl/rtc_status.sv
// Module: rtc_status
// Sticky event flags with write-one-to-clear, plus read/write interrupt
// enables. An event in the same cycle as a clear keeps its flag set.
module rtc_status
    import rtc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            st_wr,
    input  logic [ST_W-1:0] st_wdata,
    input  logic            alarm_evt,
    input  logic            sec_tick,
    output logic [ST_W-1:0] st_q,
    output logic            irq_alarm,
    output logic            irq_sec
);
    logic [1:0] flags_q;
    logic [1:0] en_q;
    logic [1:0] set_v;
    logic [1:0] clr_v;

    // Per-flag set and clear vectors (index 0 alarm, 1 seconds).
    always_comb begin
        set_v = {sec_tick, alarm_evt};
        clr_v = st_wr ? st_wdata[ST_SEC_FLAG:ST_ALM_FLAG] : 2'b00;
    end

    // Sticky flags: set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_v) | set_v;
    end

    // Interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (st_wr) en_q <= st_wdata[ST_SEC_EN:ST_ALM_EN];
    end

    // Status view and gated interrupt outputs.
    always_comb begin
        st_q      = {en_q, flags_q};
        irq_alarm = flags_q[0] && en_q[0];
        irq_sec   = flags_q[1] && en_q[1];
    end

    // R10
    alm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> flags_q[0]);
    // R10
    sec_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> flags_q[1]);
    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_wr |=> (flags_q & $past(flags_q)) == $past(flags_q));
endmodule

// File: rtl/rtc_seconds.sv
// Module: rtc_seconds (top)
// Seconds RTC with alarm. Decodes the single-cycle register bus onto the
// prescaler, the timebase and the status block. Read data is combinational
// on the address. Assumes DIV_W+TRIM_W <= DATA_W.
module rtc_seconds
    import rtc_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int DIV_W       = 16,
    parameter int TRIM_W      = 16,
    parameter int DEF_DIV     = 32767,
    parameter int TRIM_PERIOD = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_alarm,
    output logic              irq_sec
);
    localparam int CFG_W = DIV_W + TRIM_W;

    logic              wr_alm, wr_cnt, wr_cfg, wr_st;
    logic              sec_tick, alarm_evt;
    logic [CFG_W-1:0]  cfg_q;
    logic [DATA_W-1:0] cnt_q, alm_q;
    logic [ST_W-1:0]   st_q;

    // Write strobes per register.
    always_comb begin
        wr_alm = bus_we && (bus_addr == REG_ALARM);
        wr_cnt = bus_we && (bus_addr == REG_COUNT);
        wr_cfg = bus_we && (bus_addr == REG_CFG);
        wr_st  = bus_we && (bus_addr == REG_STAT);
    end

    rtc_prescaler #(
        .DIV_W(DIV_W), .TRIM_W(TRIM_W),
        .DEF_DIV(DEF_DIV), .TRIM_PERIOD(TRIM_PERIOD)
    ) u_presc (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .cfg_wr(wr_cfg), .cfg_wdata(bus_wdata[CFG_W-1:0]),
        .cfg_q(cfg_q), .sec_tick(sec_tick)
    );

    rtc_timebase #(.CNT_W(DATA_W)) u_tbase (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .cnt_wr(wr_cnt), .alm_wr(wr_alm), .wdata(bus_wdata),
        .cnt_q(cnt_q), .alm_q(alm_q), .alarm_evt(alarm_evt)
    );

    rtc_status u_stat (
        .clk(clk), .rst_n(rst_n), .st_wr(wr_st),
        .st_wdata(bus_wdata[ST_W-1:0]), .alarm_evt(alarm_evt),
        .sec_tick(sec_tick), .st_q(st_q),
        .irq_alarm(irq_alarm), .irq_sec(irq_sec)
    );

    // Read mux; unused bits return zero.
    always_comb begin
        case (bus_addr)
            REG_ALARM: bus_rdata = alm_q;
            REG_COUNT: bus_rdata = cnt_q;
            REG_CFG:   bus_rdata = DATA_W'(cfg_q);
            default:   bus_rdata = DATA_W'(st_q);
        endcase
    end

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_alarm && !irq_sec));
endmodule

// File: tb/rtc_seconds_tb.sv
// Bench for rtc_seconds: driver tasks push expected values into a
// scoreboard queue; a monitor pops and compares them against the outputs.
module rtc_seconds_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_alarm, irq_sec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int          kind_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];
    event        chk_ev;

    always #4 clk = ~clk;

    rtc_seconds u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_alarm(irq_alarm), .irq_sec(irq_sec)
    );

    // Monitor: pop expected items and compare with the live outputs.
    always @(chk_ev) begin : mon
        int          k;
        logic [31:0] e, a;
        string       t;
        while (kind_q.size() > 0) begin
            k = kind_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = (k == 0) ? bus_rdata : (k == 1) ? {31'b0, irq_alarm} : {31'b0, irq_sec};
            checks++;
            if (a !== e) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", t, a, e);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic run_en(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic exp_reg(input logic [1:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr = a;
        #2;
        kind_q.push_back(0); exp_q.push_back(e); tag_q.push_back(t);
        -> chk_ev;
    endtask

    task automatic exp_irq(input int which, input logic e, input string t);
        @(negedge clk);
        #2;
        kind_q.push_back(which); exp_q.push_back({31'b0, e}); tag_q.push_back(t);
        -> chk_ev;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        exp_reg(2'd0, 32'h0, "R1 alarm");
        exp_reg(2'd1, 32'h0, "R1 count");
        exp_reg(2'd2, 32'h0, "R1 cfg");
        exp_reg(2'd3, 32'h0, "R1 status");
        exp_irq(1, 1'b0, "R1 irq_alarm");
        exp_irq(2, 1'b0, "R1 irq_sec");
        // R4 zero register means default divider
        run_en(32767);
        exp_reg(2'd1, 32'd0, "R4 before default wrap");
        run_en(1);
        exp_reg(2'd1, 32'd1, "R4 default wrap");
        // R9 flag recorded with enable off
        exp_reg(2'd3, 32'h2, "R9 flag without enable");
        exp_irq(2, 1'b0, "R9 irq_sec masked");
        // R3 programmed divider
        wr(2'd2, 32'd3);
        exp_reg(2'd2, 32'd3, "R2 cfg readback");
        wr(2'd1, 32'd100);
        wr(2'd3, 32'h3);
        exp_reg(2'd3, 32'h0, "R8 clear both flags");
        run_en(3);
        exp_reg(2'd1, 32'd100, "R3 no tick before div+1");
        run_en(1);
        exp_reg(2'd1, 32'd101, "R3 tick at div+1");
        run_en(8);
        exp_reg(2'd1, 32'd103, "R6 two more ticks");
        exp_reg(2'd3, 32'h2, "R9 sec flag set");
        // R8 write zero no effect, write one clears
        wr(2'd3, 32'h0);
        exp_reg(2'd3, 32'h2, "R8 zero write keeps flag");
        wr(2'd3, 32'h2);
        exp_reg(2'd3, 32'h0, "R8 one write clears flag");
        // R9 enable gates interrupt
        wr(2'd3, 32'h8);
        exp_irq(2, 1'b0, "R9 enable without flag");
        run_en(4);
        exp_reg(2'd1, 32'd104, "R6 count");
        exp_reg(2'd3, 32'hA, "R9 flag and enable");
        exp_irq(2, 1'b1, "R9 irq_sec asserted");
        exp_irq(1, 1'b0, "R9 irq_alarm idle");
        // R2 alarm register and unused status bits
        wr(2'd0, 32'd106);
        exp_reg(2'd0, 32'd106, "R2 alarm readback");
        wr(2'd3, 32'hFFFF_FFFF);
        exp_reg(2'd3, 32'hC, "R2 unused status bits zero");
        // R7 alarm on tick match
        run_en(4);
        exp_reg(2'd3, 32'hE, "R7 no alarm before match");
        exp_irq(1, 1'b0, "R7 irq_alarm before match");
        run_en(4);
        exp_reg(2'd1, 32'd106, "R7 count at match");
        exp_reg(2'd3, 32'hF, "R7 alarm flag set");
        exp_irq(1, 1'b1, "R7 irq_alarm asserted");
        wr(2'd3, 32'hD);
        exp_reg(2'd3, 32'hE, "R8 clear alarm only");
        exp_irq(1, 1'b0, "R8 irq_alarm cleared");
        wr(2'd1, 32'd106);
        exp_reg(2'd3, 32'hE, "R7 write to alarm value no event");
        // R10 tick collides with clear of its flag
        run_en(3);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 2'd3; bus_wdata = 32'hE; tick_en = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick_en = 1'b0;
        exp_reg(2'd1, 32'd107, "R10 tick taken");
        exp_reg(2'd3, 32'hE, "R10 event beats clear");
        // R5 positive trim
        wr(2'd2, 32'h0002_0003);
        wr(2'd1, 32'd0);
        run_en(4092);
        exp_reg(2'd1, 32'd1023, "R5 normal periods");
        run_en(5);
        exp_reg(2'd1, 32'd1023, "R5 lengthened period pending");
        run_en(1);
        exp_reg(2'd1, 32'd1024, "R5 lengthened period done");
        run_en(4);
        exp_reg(2'd1, 32'd1025, "R5 normal after trim");
        // R5 negative trim
        wr(2'd2, 32'hFFFF_0003);
        exp_reg(2'd2, 32'hFFFF_0003, "R2 trim field readback");
        wr(2'd1, 32'd0);
        run_en(4092);
        exp_reg(2'd1, 32'd1023, "R5 negative normal periods");
        run_en(2);
        exp_reg(2'd1, 32'd1023, "R5 shortened period pending");
        run_en(1);
        exp_reg(2'd1, 32'd1024, "R5 shortened period done");
        // R4 return to default by writing zero
        wr(2'd2, 32'd0);
        wr(2'd1, 32'd0);
        run_en(32767);
        exp_reg(2'd1, 32'd0, "R4 zero write before wrap");
        run_en(1);
        exp_reg(2'd1, 32'd1, "R4 zero write wrap");
        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule